// File: doc/BRIEF.md
# Two-Stage PWM Rate Prescaler

This block derives a family of rate strobes from a single master clock for a bank of PWM channels. A free-running binary counter forms eleven power-of-two taps: the master rate itself and the master rate divided by 2 through 1024. Two programmable dividers, A and B, each pick one tap and divide it again by an integer from 1 to 255. The result is two additional rates whose period is any product of a power of two and an 8-bit value.

Every output is a one-cycle enable pulse in the master clock domain, not a generated clock. Downstream channel counters advance only on the strobe they select. All thirteen strobes are exposed, so each channel can choose its own rate. Configuration is applied through plain input ports and may change at any time. A change restarts the affected divider cleanly.

Top module: `pwm_rate_gen`

## Requirements
- R1: Tap k (k = 0..10 on `tap_en[k]`) is high for exactly one master cycle in every 2^k cycles. Tap 0 is high in every cycle. Counting c master edges since reset was released, tap k is high while (c+1) is a multiple of 2^k.
- R2: While `rst_n` is low at a clock edge, the prescaler and both divider counters are cleared. During reset, `rate_a_en` and `rate_b_en` are low and `tap_en` equals 1.
- R3: Divider A takes tap `sel_a` and pulses once every `div_a` pulses of that tap. In steady configuration, its pulse spacing is 2^`sel_a` × `div_a` master cycles, for divisors from 1 to 255.
- R4: Divider B does the same with `sel_b` and `div_b`, independently of divider A's settings and state.
- R5: With a divisor of 1 and an unchanged configuration, a divider output equals its selected tap cycle for cycle.
- R6: A divisor of 0 holds that divider's output low.
- R7: A select value from 11 to 15 is reserved and holds that divider's output low.
- R8: In the cycle a divider's select or divisor value differs from the previous cycle, that divider emits no pulse and restarts its count. Its next pulse coincides with the N-th selected tap pulse after that cycle.
- R9: A divider pulse only ever occurs in a cycle where its selected tap is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_a | input | 4 | Tap select for divider A (0..10 valid) |
| div_a | input | 8 | Divisor for divider A (0 disables) |
| sel_b | input | 4 | Tap select for divider B (0..10 valid) |
| div_b | input | 8 | Divisor for divider B (0 disables) |
| tap_en | output | 11 | Power-of-two rate strobes, bit k every 2^k cycles |
| rate_a_en | output | 1 | Divider A strobe |
| rate_b_en | output | 1 | Divider B strobe |

## Verification
A corrupted prescaler count moves every tap phase at once, and the next low-order tap shows it within one or two cycles. A stuck high-order bit shows only at the next 1024-cycle boundary. A divider counter that wraps at the wrong value, or fails to restart on a change, shifts the next strobe by whole tap periods. The error therefore appears at the first output pulse after the fault, up to 2^10 × 255 cycles later for the slowest setting. The bench predicts every strobe in every cycle and also measures pulse spacing, so both phase and period errors surface at the first affected pulse.

// File: rtl/pwm_rate_gen.sv
module pwm_rate_gen #(
  parameter int TAPS = 11,
  parameter int SELW = 4,
  parameter int DIVW = 8
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] sel_a,
  input  logic [DIVW-1:0] div_a,
  input  logic [SELW-1:0] sel_b,
  input  logic [DIVW-1:0] div_b,
  output logic [TAPS-1:0] tap_en,
  output logic            rate_a_en,
  output logic            rate_b_en
);
  localparam int PW   = TAPS - 1;
  localparam int SELN = 1 << SELW;

  logic [PW-1:0]   pre_q;
  logic [SELN-1:0] tap_pad;
  logic [SELW-1:0] sel_in [2];
  logic [DIVW-1:0] div_in [2];
  logic [1:0]      rate;

  always_ff @(posedge clk)
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;

  assign tap_en[0] = 1'b1;

  generate
    for (genvar k = 1; k < TAPS; k++) begin : g_tap
      assign tap_en[k] = &pre_q[k-1:0];
      if (k >= 2) begin : g_nest
        a_r1_tap_nested: assert property (@(posedge clk) disable iff (!rst_n)
          tap_en[k] |-> tap_en[k-1]);
      end
    end
  endgenerate

  a_r1_tap1_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    tap_en[1] |=> !tap_en[1]);
  a_r1_top_tap_single: assert property (@(posedge clk) disable iff (!rst_n)
    tap_en[TAPS-1] |=> !tap_en[TAPS-1]);

  assign tap_pad   = SELN'(tap_en);
  assign sel_in[0] = sel_a;
  assign sel_in[1] = sel_b;
  assign div_in[0] = div_a;
  assign div_in[1] = div_b;
  assign rate_a_en = rate[0];
  assign rate_b_en = rate[1];

  generate
    for (genvar d = 0; d < 2; d++) begin : g_div
      logic [SELW-1:0] sel_q;
      logic [DIVW-1:0] div_q;
      logic [DIVW-1:0] cnt_q;
      logic            ok, chg, hit, wrap;

      assign ok   = (div_in[d] != '0) && (int'(sel_in[d]) < TAPS);
      assign chg  = (sel_in[d] != sel_q) || (div_in[d] != div_q);
      assign hit  = ok && !chg && tap_pad[sel_in[d]];
      assign wrap = (cnt_q == div_in[d] - 1'b1);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sel_q <= '0;
          div_q <= '0;
          cnt_q <= '0;
        end else if (chg) begin
          sel_q <= sel_in[d];
          div_q <= div_in[d];
          cnt_q <= '0;
        end else if (!ok) begin
          cnt_q <= '0;
        end else if (hit) begin
          cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
      end

      assign rate[d] = rst_n && hit && wrap;

      a_r9_pulse_on_tap: assert property (@(posedge clk) disable iff (!rst_n)
        rate[d] |-> tap_pad[sel_in[d]]);
      a_r6_zero_div_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (div_in[d] == '0) |-> !rate[d]);
      a_r7_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel_in[d]) >= TAPS) |-> !rate[d]);
      a_r8_no_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_in[d] != $past(sel_in[d]) || div_in[d] != $past(div_in[d])) |-> !rate[d]);
      a_r5_unit_div_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && div_in[d] == 1 && int'(sel_in[d]) < TAPS
         && $stable(sel_in[d]) && $stable(div_in[d]) && $past(sel_in[d]) == $past(sel_in[d], 2)
         && $past(div_in[d]) == $past(div_in[d], 2))
        |-> (rate[d] == tap_pad[sel_in[d]]));
    end
  endgenerate

  a_r2_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!rate_a_en && !rate_b_en));
endmodule

// File: tb/pwm_rate_gen_bench.sv
`timescale 1ns/100ps
module pwm_rate_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] sel_a = 4'd0, sel_b = 4'd3;
  logic [7:0] div_a = 8'd1, div_b = 8'd5;
  logic [10:0] tap_en;
  logic rate_a_en, rate_b_en;

  always #2.5 clk = ~clk;

  pwm_rate_gen u_pwm_rate_gen (
    .clk(clk), .rst_n(rst_n),
    .sel_a(sel_a), .div_a(div_a), .sel_b(sel_b), .div_b(div_b),
    .tap_en(tap_en), .rate_a_en(rate_a_en), .rate_b_en(rate_b_en));

  typedef struct {
    logic [10:0] taps;
    logic [1:0]  rate;
    logic [1:0]  chg;
    int          period [2];
    string       tag_t;
    string       tag_r [2];
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, failures = 0;
  bit done = 1'b0;

  int p = 0;
  logic [3:0] ps [2] = '{4'd0, 4'd0};
  logic [7:0] pd [2] = '{8'd0, 8'd0};
  int m [2] = '{0, 0};

  function automatic logic [10:0] model_taps(int cnt);
    logic [10:0] t;
    for (int k = 0; k < 11; k++) t[k] = ((cnt + 1) % (1 << k)) == 0;
    return t;
  endfunction

  // predictor: pushes expected values for the current cycle, then advances the model
  always @(negedge clk) begin
    exp_t e;
    logic [3:0] s [2];
    logic [7:0] dv [2];
    s[0] = sel_a; s[1] = sel_b; dv[0] = div_a; dv[1] = div_b;
    e.taps = model_taps(p);
    e.tag_t = rst_n ? "R1" : "R2";
    for (int d = 0; d < 2; d++) begin
      bit valid, ch, tp;
      valid = (dv[d] != 0) && (s[d] < 11);
      ch = (s[d] != ps[d]) || (dv[d] != pd[d]);
      tp = valid && e.taps[s[d]];
      e.rate[d] = rst_n && valid && !ch && tp && (m[d] == dv[d] - 1);
      e.chg[d] = ch || !rst_n || !valid;
      e.period[d] = (1 << s[d]) * dv[d];
      if (!rst_n) e.tag_r[d] = "R2";
      else if (dv[d] == 0) e.tag_r[d] = "R6";
      else if (s[d] >= 11) e.tag_r[d] = "R7";
      else if (ch) e.tag_r[d] = "R8";
      else if (dv[d] == 1) e.tag_r[d] = "R5";
      else e.tag_r[d] = (d == 0) ? "R3" : "R4";
      if (!rst_n) begin ps[d] = 0; pd[d] = 0; m[d] = 0; end
      else if (ch) begin ps[d] = s[d]; pd[d] = dv[d]; m[d] = 0; end
      else if (!valid) m[d] = 0;
      else if (tp) m[d] = (m[d] + 1 == dv[d]) ? 0 : m[d] + 1;
    end
    p = rst_n ? (p + 1) % 1024 : 0;
    exp_q.push_back(e);
  end

  int cyc = 0;
  int last [2] = '{-1, -1};

  // monitor: pops expectations and compares against the ports
  always @(negedge clk) begin
    #1;
    if (!done && exp_q.size() > 0) begin
      exp_t e;
      logic [1:0] act;
      e = exp_q.pop_front();
      act = {rate_b_en, rate_a_en};
      checks++;
      if (tap_en !== e.taps) begin
        failures++;
        $display("FAIL %s taps cyc=%0d actual=%b expected=%b", e.tag_t, cyc, tap_en, e.taps);
      end
      for (int d = 0; d < 2; d++) begin
        checks++;
        if (act[d] !== e.rate[d]) begin
          failures++;
          $display("FAIL %s rate%0d cyc=%0d actual=%b expected=%b", e.tag_r[d], d, cyc, act[d], e.rate[d]);
        end
        if (e.chg[d]) last[d] = -1;
        if (act[d] === 1'b1) begin
          if (last[d] >= 0) begin
            checks++;
            if (cyc - last[d] != e.period[d]) begin
              failures++;
              $display("FAIL %s R9 spacing rate%0d actual=%0d expected=%0d",
                       (d == 0) ? "R3" : "R4", d, cyc - last[d], e.period[d]);
            end
          end
          last[d] = cyc;
        end
      end
      cyc++;
    end
  end

  task automatic cfg(input logic [3:0] sa, input logic [7:0] da,
                     input logic [3:0] sb, input logic [7:0] db, input int n);
    @(posedge clk); #1;
    sel_a = sa; div_a = da; sel_b = sb; div_b = db;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (200) @(posedge clk);
    cfg(4'd10, 8'd1, 4'd0, 8'd255, 3200);
    cfg(4'd2, 8'd255, 4'd12, 8'd7, 2600);
    cfg(4'd3, 8'd0, 4'd15, 8'd1, 120);
    cfg(4'd1, 8'd3, 4'd4, 8'd2, 300);
    cfg(4'd1, 8'd4, 4'd4, 8'd2, 300);
    cfg(4'd5, 8'd1, 4'd0, 8'd1, 200);
    cfg(4'd0, 8'd2, 4'd6, 8'd3, 50);
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (500) @(posedge clk);
    @(negedge clk); #2;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule